// File: doc/BRIEF.md
# Link-Layer Packet Framer

This block sits between a transaction-layer packet source and the physical coding stage of a serial link. It takes one already-formed packet at a time from a byte-wide stream that has valid, ready, start-of-packet and end-of-packet marks. It emits the framed packet one byte per clock, and each output byte carries a flag that separates control symbols from data bytes.

Around the packet body it adds five things. At the front come a start symbol and a two-byte sequence field. At the back come a four-byte link CRC and an end symbol. The block keeps its own sequence counter. The CRC covers the sequence field and every body byte, but not the two symbols. The body can hold a header, a payload and an end-to-end CRC, and the block passes all of it through unchanged. While the block emits its own bytes, it holds the upstream ready low, so no input byte is lost.

Top module: `lnk_framer`

## Requirements
- R1: After reset, with no input offered, `out_valid` is 0 and `in_ready` is 0.
- R2: A frame leaves in this order: start symbol, sequence high byte, sequence low byte, every body byte in arrival order, four CRC bytes, end symbol. The start symbol is 0xFB and the end symbol is 0xFD, both with `out_ctrl`=1. Every other byte has `out_ctrl`=0.
- R3: The sequence high byte is {4'b0, seq[11:8]} and the low byte is seq[7:0]. The first frame after reset uses seq 0. Each later frame uses the previous value plus one, and 4095 is followed by 0.
- R4: The CRC uses the polynomial 0x04C11DB7 with seed 0xFFFFFFFF, and each byte is fed most significant bit first. It runs over the two sequence bytes and then the body bytes. The complement of the final value is sent with bits [31:24] first and bits [7:0] last.
- R5: `in_ready` is 0 in the cycles where the block prepares the start symbol, the sequence bytes, the CRC bytes and the end symbol. No input byte is taken in those cycles.
- R6: When `in_valid` drops in the middle of a body, the output pauses with `out_valid`=0. The frame then resumes with no byte lost or repeated.
- R7: A byte offered while idle without `in_sop` is consumed (`in_ready`=1) and dropped, and it produces no output byte.
- R8: Body lengths from 12 bytes (a three-doubleword header) up to 4116 bytes (a four-doubleword header, a 1024-doubleword payload and a one-doubleword end-to-end CRC) are framed correctly.
- R9: The start symbol appears one cycle after a start-marked byte is offered in idle. When the input has no gaps, all len+8 output bytes of a frame come out on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Upstream byte accepted this cycle when high with in_valid |
| in_data | input | 8 | Upstream packet byte |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_eop | input | 1 | Marks the last byte of a packet |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Framed output byte |
| out_ctrl | output | 1 | 1 when out_data is a control symbol |

## Verification
The bench builds the block with its default 12-bit sequence width. It sends 4098 frames, which sweeps every sequence value, covers the wrap from 4095 back to 0 and reaches the first values again. Every frame is compared byte for byte against a CRC that the bench computes one bit at a time. Two frames cover the length extremes: a bare three-doubleword header, and a four-doubleword header with the largest payload and an end-to-end CRC. Other cases cover a body with input gaps and stray bytes offered while idle.

// File: rtl/lnk_frm_pkg.sv
package lnk_frm_pkg;
  localparam logic [7:0]  SYM_START = 8'hFB;
  localparam logic [7:0]  SYM_END   = 8'hFD;
  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEQH, ST_SEQL, ST_BODY, ST_CRC, ST_END
  } frm_state_t;

  // One byte folded into the CRC, most significant bit first.
  function automatic logic [31:0] crc_fold_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {d, 24'h0};
    for (int k = 0; k < 8; k++)
      r = r[31] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/lnk_crc_unit.sv
module lnk_crc_unit
  import lnk_frm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed,
  input  logic        fold,
  input  logic [7:0]  din,
  output logic [31:0] crc_tx
);
  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (seed)  crc_q <= CRC_SEED;
    else if (fold)  crc_q <= crc_fold_byte(crc_q, din);
  end

  assign crc_tx = ~crc_q;
endmodule

// File: rtl/lnk_seq_ctr.sv
module lnk_seq_ctr #(
  parameter int SEQ_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SEQ_W-1:0] seq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   seq <= '0;
    else if (adv) seq <= seq + 1'b1;
  end
endmodule

// File: rtl/lnk_frame_ctl.sv
module lnk_frame_ctl
  import lnk_frm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  output frm_state_t st,
  output logic [1:0] crc_idx,
  output logic       in_ready
);
  assign in_ready = (st == ST_BODY) || (st == ST_IDLE && in_valid && !in_sop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      crc_idx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (in_valid && in_sop) st <= ST_SEQH;
        ST_SEQH: st <= ST_SEQL;
        ST_SEQL: st <= ST_BODY;
        ST_BODY: if (in_valid && in_eop) begin
          st      <= ST_CRC;
          crc_idx <= '0;
        end
        ST_CRC: begin
          crc_idx <= crc_idx + 1'b1;
          if (crc_idx == 2'd3) st <= ST_END;
        end
        ST_END:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lnk_framer.sv
module lnk_framer
  import lnk_frm_pkg::*;
#(
  parameter int SEQ_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_ctrl
);
  frm_state_t       st;
  logic [1:0]       crc_idx;
  logic [1:0]       crc_rev;
  logic [SEQ_W-1:0] seq_val;
  logic [15:0]      seq_field;
  logic [31:0]      crc_tx;
  logic             nxt_valid, nxt_ctrl, crc_fold;
  logic [7:0]       nxt_data;

  // Named events for the checker
  logic ovh_phase, frame_done, idle_stray;
  assign ovh_phase  = (st == ST_SEQH) || (st == ST_SEQL) || (st == ST_CRC) || (st == ST_END);
  assign frame_done = (st == ST_END);
  assign idle_stray = (st == ST_IDLE) && in_valid && !in_sop;

  lnk_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .st(st), .crc_idx(crc_idx), .in_ready(in_ready)
  );

  lnk_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(frame_done), .seq(seq_val)
  );

  assign seq_field = 16'(seq_val);
  assign crc_rev   = 2'd3 - crc_idx;

  always_comb begin
    nxt_valid = 1'b0;
    nxt_ctrl  = 1'b0;
    nxt_data  = 8'h00;
    crc_fold  = 1'b0;
    case (st)
      ST_IDLE: if (in_valid && in_sop) begin
        nxt_valid = 1'b1; nxt_ctrl = 1'b1; nxt_data = SYM_START;
      end
      ST_SEQH: begin nxt_valid = 1'b1; nxt_data = seq_field[15:8]; crc_fold = 1'b1; end
      ST_SEQL: begin nxt_valid = 1'b1; nxt_data = seq_field[7:0];  crc_fold = 1'b1; end
      ST_BODY: if (in_valid) begin
        nxt_valid = 1'b1; nxt_data = in_data; crc_fold = 1'b1;
      end
      ST_CRC:  begin nxt_valid = 1'b1; nxt_data = crc_tx[{crc_rev, 3'b000} +: 8]; end
      ST_END:  begin nxt_valid = 1'b1; nxt_ctrl = 1'b1; nxt_data = SYM_END; end
      default: ;
    endcase
  end

  lnk_crc_unit u_crc (
    .clk(clk), .rst_n(rst_n), .seed(st == ST_IDLE), .fold(crc_fold),
    .din(nxt_data), .crc_tx(crc_tx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_ctrl  <= 1'b0;
    end else begin
      out_valid <= nxt_valid;
      out_data  <= nxt_data;
      out_ctrl  <= nxt_ctrl;
    end
  end
endmodule

module lnk_framer_chk #(
  parameter int SEQ_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_ctrl,
  input logic             ovh_phase,
  input logic             frame_done,
  input logic             idle_stray,
  input logic [SEQ_W-1:0] seq_val
);
  logic [SEQ_W-1:0] seq_inc;
  assign seq_inc = seq_val + 1'b1;

  p_ready_low_ovh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovh_phase |-> !in_ready);

  p_ctrl_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ctrl) |-> (out_data == 8'hFB || out_data == 8'hFD));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (seq_val == $past(seq_inc)));

  p_stray_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_stray && in_ready) |=> !out_valid);

  p_start_then_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ctrl && out_data == 8'hFB) |=> (out_valid && !out_ctrl));
endmodule

bind lnk_framer lnk_framer_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl),
  .ovh_phase(ovh_phase), .frame_done(frame_done), .idle_stray(idle_stray),
  .seq_val(seq_val)
);

// File: tb/lnk_framer_bench.sv
module lnk_framer_bench;
  localparam int SEQ_W = 12;
  localparam int MAXB  = 4200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_ctrl;
  logic [7:0] out_data;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int cap_n = 0, ovh_viol = 0;
  bit end_seen = 1'b0;
  logic [7:0] cap_d [MAXB];
  bit         cap_c [MAXB];
  int         cap_t [MAXB];
  logic [7:0] body  [MAXB];

  lnk_framer #(.SEQ_W(SEQ_W)) u_lnk_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (out_valid && cap_n < MAXB) begin
      if (cap_n < 2 && in_ready) ovh_viol++;
      cap_d[cap_n] = out_data;
      cap_c[cap_n] = out_ctrl;
      cap_t[cap_n] = cyc;
      cap_n++;
      if (out_ctrl && out_data == 8'hFD) end_seen = 1'b1;
    end
  end

  function automatic logic [31:0] ref_bit(input logic [31:0] c, input logic b);
    logic fb;
    fb = c[31] ^ b;
    c  = {c[30:0], 1'b0};
    if (fb) c = c ^ 32'h04C11DB7;
    return c;
  endfunction

  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] d);
    for (int b = 7; b >= 0; b--) c = ref_bit(c, d[b]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit sop, input bit eop);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sop = sop; in_eop = eop;
      #1;
      if (in_ready) begin @(posedge clk); done = 1'b1; end
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send_frame(input int len, input bit gaps, input int f);
    logic [31:0] crc;
    logic [15:0] sq;
    logic [7:0]  e;
    int mism;
    @(posedge clk);
    cap_n = 0; end_seen = 1'b0; ovh_viol = 0;
    for (int i = 0; i < len; i++) body[i] = 8'((i * 7) + (f * 13) + 5);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 2)) begin go_idle(); @(posedge clk); end
      send_byte(body[i], i == 0, i == len - 1);
    end
    go_idle();
    while (!end_seen) @(posedge clk);
    // expected frame
    sq  = 16'(f % 4096);
    crc = 32'hFFFFFFFF;
    crc = ref_byte(crc, sq[15:8]);
    crc = ref_byte(crc, sq[7:0]);
    for (int i = 0; i < len; i++) crc = ref_byte(crc, body[i]);
    crc  = ~crc;
    mism = 0;
    chk(cap_n == len + 8, "R8", "frame length", cap_n, len + 8);
    for (int p = 0; p < len + 8 && p < cap_n; p++) begin
      bit ec;
      ec = (p == 0) || (p == len + 7);
      if (p == 0) e = 8'hFB;
      else if (p == 1) e = sq[15:8];
      else if (p == 2) e = sq[7:0];
      else if (p < len + 3) e = body[p - 3];
      else if (p < len + 7) e = crc[8 * (3 - (p - len - 3)) +: 8];
      else e = 8'hFD;
      if ((cap_d[p] !== e || cap_c[p] !== ec) && mism == 0) begin
        mism = 1;
        if (p == 1 || p == 2)   chk(0, "R3", "sequence byte", cap_d[p], e);
        else if (p >= len + 3 && p < len + 7) chk(0, "R4", "crc byte", cap_d[p], e);
        else chk(0, "R2", "frame byte/flag", {cap_c[p], cap_d[p]}, {ec, e});
      end
    end
    if (mism == 0) chk(1, "R2", "frame content", 0, 0);
    chk(ovh_viol == 0, "R5", "ready during overhead", ovh_viol, 0);
    if (!gaps && cap_n == len + 8)
      chk(cap_t[cap_n - 1] - cap_t[0] == len + 7, "R9", "contiguous frame",
          cap_t[cap_n - 1] - cap_t[0], len + 7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);

    // R7: stray bytes while idle are consumed and dropped
    @(posedge clk);
    cap_n = 0;
    for (int i = 0; i < 3; i++) send_byte(8'hA0 + 8'(i), 1'b0, 1'b0);
    go_idle();
    repeat (3) @(posedge clk);
    chk(cap_n == 0, "R7", "output from stray bytes", cap_n, 0);

    // R8 smallest body, seq 0 (R3)
    send_frame(12, 1'b0, 0);
    // R8 largest body: 4 DW header + 1024 DW payload + 1 DW end-to-end CRC
    send_frame(16 + 4096 + 4, 1'b0, 1);
    // R6 body with input gaps
    send_frame(20, 1'b1, 2);
    // R3 sweep through every sequence value and past the wrap
    for (int f = 3; f < 4098; f++) send_frame(12, 1'b0, f);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule